// File: doc/BRIEF.md
# UART Channel Data Register Block

This block sits between a processor bus and the shift registers of one UART channel. It holds one received character and one character waiting to be sent. Both share a single data address: a bus read there returns the received character and a bus write there queues a transmit character. A second address holds the channel's control bits and the status flags.

The receiver hands over each completed character with a one-cycle load pulse, together with its parity and framing error indications. The block sets the receive-full flag and detects overrun. It raises a receive interrupt while the flag is set and the interrupt is enabled. On the transmit side, a queued character moves to the transmit shift register with a one-cycle take pulse as soon as the shifter reports idle. This gives one level of double buffering. A short-frame mode treats the top data bit as unused.

Top module: `uart_data_regs`

## Requirements
- R1: After reset the status byte at address 1 reads 8'h01: transmit-empty set, receive-full clear, no errors, and all control bits clear. `rx_irq_o` is 0.
- R2: A read at address 0 (`bus_addr_i`=0) returns the held received character combinationally in the same cycle.
- R3: A read at address 0 clears receive-full (status bit 1) from the next cycle, unless a new character loads in that same cycle.
- R4: Address 0 is shared. A write there goes to the transmit register and never changes what a read at address 0 returns.
- R5: `rx_irq_o` is 1 exactly while receive-full is set and the interrupt enable (status/control bit 7) is 1.
- R6: A load while receive-full is set and no read is under way sets overrun (status bit 4). The held character is kept and the new one is dropped. A read at address 0 clears overrun.
- R7: Status bit 2 (parity) and bit 3 (framing) show the error indications that came with the held character.
- R8: With short frames (control bit 5 = 1), bit 7 reads 0 on both the received data and `tx_data_o`.
- R9: A write at address 0 with transmit enable (control bit 6) set stores the character and clears transmit-empty (status bit 0).
- R10: While transmit-empty is 0 and `tx_busy_i` is 0, `tx_take_o` is 1 with the character on `tx_data_o`. Transmit-empty returns to 1 on the next cycle. `tx_take_o` is never 1 while `tx_busy_i` is 1.
- R11: A write at address 0 with transmit enable clear is ignored. Transmit-empty stays 1 and no take occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | 1 | 0 = data, 1 = control/status |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| rx_load_i | input | 1 | Receiver character complete |
| rx_data_i | input | 8 | Received character |
| rx_pe_i | input | 1 | Parity error of that character |
| rx_fe_i | input | 1 | Framing error of that character |
| rx_irq_o | output | 1 | Receive interrupt request |
| tx_busy_i | input | 1 | Transmit shifter busy |
| tx_take_o | output | 1 | Character moves to the shifter this cycle |
| tx_data_o | output | 8 | Character for the shifter |

## Verification
The bench loads two characters with no read between them. A design that overwrote on overrun would return the second character instead of the first, and one that missed the overrun would show status bit 4 clear. It writes the data address while the shifter is busy and again with transmit disabled. Taking early, or accepting the disabled write, shows up as a take pulse or as a cleared empty flag. Short-frame mode is checked with all-ones data on both paths, where a missing mask leaves bit 7 set. A read at the data address after a transmit write catches a design that routes writes into the receive register.

// File: rtl/uart_dreg_pkg.sv
package uart_dreg_pkg;
  localparam int unsigned BUS_W     = 8;
  // status/control bit positions at address 1
  localparam int unsigned ST_TDRE   = 0;
  localparam int unsigned ST_RDRF   = 1;
  localparam int unsigned ST_PE     = 2;
  localparam int unsigned ST_FE     = 3;
  localparam int unsigned ST_ORE    = 4;
  localparam int unsigned CT_SHORT  = 5;
  localparam int unsigned CT_TXEN   = 6;
  localparam int unsigned CT_RXIE   = 7;

  typedef struct packed {
    logic rx_ie;
    logic tx_en;
    logic len_short;
  } ctrl_t;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pe_i,
  input  logic              fe_i,
  input  logic              rd_i,
  input  logic              len_short_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              pe_o,
  output logic              fe_o,
  output logic              ore_o
);
  logic [DATA_W-1:0] hold_q;
  logic              accept;

  assign accept = load_i & (~full_o | rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_o <= 1'b0;
      pe_o   <= 1'b0;
      fe_o   <= 1'b0;
      ore_o  <= 1'b0;
    end else begin
      if (accept) begin
        hold_q <= data_i;
        pe_o   <= pe_i;
        fe_o   <= fe_i;
        full_o <= 1'b1;
      end else if (rd_i) begin
        pe_o   <= 1'b0;
        fe_o   <= 1'b0;
        full_o <= 1'b0;
      end
      // new character dropped, old one kept
      if (load_i && full_o && !rd_i) ore_o <= 1'b1;
      else if (rd_i)                 ore_o <= 1'b0;
    end
  end

  assign data_o = len_short_i ? {1'b0, hold_q[DATA_W-2:0]} : hold_q;
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              en_i,
  input  logic              len_short_i,
  input  logic              busy_i,
  output logic              take_o,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] hold_q;
  logic              wr_ok;

  assign wr_ok  = wr_i & en_i;
  assign take_o = ~empty_o & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      empty_o <= 1'b1;
    end else if (wr_ok) begin
      hold_q  <= wdata_i;
      empty_o <= 1'b0;
    end else if (take_o) begin
      empty_o <= 1'b1;
    end
  end

  assign data_o = len_short_i ? {1'b0, hold_q[DATA_W-2:0]} : hold_q;
endmodule

// File: rtl/uart_data_regs.sv
module uart_data_regs
  import uart_dreg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pe_i,
  input  logic              rx_fe_i,
  output logic              rx_irq_o,
  input  logic              tx_busy_i,
  output logic              tx_take_o,
  output logic [DATA_W-1:0] tx_data_o
);
  localparam int unsigned PAD_W = (BUS_W > DATA_W) ? BUS_W - DATA_W : 0;

  ctrl_t             ctrl_q;
  logic              data_rd, data_wr;
  logic [DATA_W-1:0] rx_data;
  logic              rx_full, rx_pe, rx_fe, rx_ore, tx_empty;
  logic [BUS_W-1:0]  status;

  assign data_rd = bus_rd_i & ~bus_addr_i;
  assign data_wr = bus_wr_i & ~bus_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ctrl_q <= '0;
    else if (bus_wr_i && bus_addr_i) ctrl_q <= '{rx_ie:     bus_wdata_i[CT_RXIE],
                                                 tx_en:     bus_wdata_i[CT_TXEN],
                                                 len_short: bus_wdata_i[CT_SHORT]};
  end

  uart_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .load_i(rx_load_i), .data_i(rx_data_i), .pe_i(rx_pe_i), .fe_i(rx_fe_i),
    .rd_i(data_rd), .len_short_i(ctrl_q.len_short),
    .data_o(rx_data), .full_o(rx_full), .pe_o(rx_pe), .fe_o(rx_fe), .ore_o(rx_ore)
  );

  uart_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_i(data_wr), .wdata_i(bus_wdata_i[DATA_W-1:0]), .en_i(ctrl_q.tx_en),
    .len_short_i(ctrl_q.len_short), .busy_i(tx_busy_i),
    .take_o(tx_take_o), .data_o(tx_data_o), .empty_o(tx_empty)
  );

  always_comb begin
    status           = '0;
    status[ST_TDRE]  = tx_empty;
    status[ST_RDRF]  = rx_full;
    status[ST_PE]    = rx_pe;
    status[ST_FE]    = rx_fe;
    status[ST_ORE]   = rx_ore;
    status[CT_SHORT] = ctrl_q.len_short;
    status[CT_TXEN]  = ctrl_q.tx_en;
    status[CT_RXIE]  = ctrl_q.rx_ie;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign bus_rdata_o = bus_addr_i ? status : {{PAD_W{1'b0}}, rx_data};
    end else begin : g_nopad
      assign bus_rdata_o = bus_addr_i ? status : rx_data[BUS_W-1:0];
    end
  endgenerate

  assign rx_irq_o = rx_full & ctrl_q.rx_ie;
endmodule

// File: rtl/uart_data_regs_chk.sv
module uart_data_regs_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_load_i,
  input logic              data_rd,
  input logic              bus_wr_i,
  input logic              rx_full,
  input logic              rx_ore,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_empty,
  input logic              tx_take_o,
  input logic              tx_busy_i,
  input logic              rx_irq_o
);
  a_r2_load_sets_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_i && !rx_full |=> rx_full);
  a_r3_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd && !rx_load_i |=> !rx_full);
  a_r6_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_load_i && rx_full && !data_rd |=> rx_ore && $stable(rx_data));
  a_r10_no_take_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |-> !tx_take_o);
  a_r10_take_refills_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_take_o && !bus_wr_i |=> tx_empty);
  a_r5_irq_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> rx_full);
endmodule

bind uart_data_regs uart_data_regs_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .rx_load_i, .data_rd, .bus_wr_i, .rx_full, .rx_ore,
  .rx_data, .tx_empty, .tx_take_o, .tx_busy_i, .rx_irq_o
);

// File: tb/uart_data_regs_tb.sv
module uart_data_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 0, rst_ni = 0;
  logic       bus_addr_i = 0, bus_rd_i = 0, bus_wr_i = 0;
  logic [7:0] bus_wdata_i = 0, bus_rdata_o;
  logic       rx_load_i = 0, rx_pe_i = 0, rx_fe_i = 0, rx_irq_o;
  logic [7:0] rx_data_i = 0, tx_data_o;
  logic       tx_busy_i = 1, tx_take_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_data_regs u_dut (.*);

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic a, logic [7:0] d);
    @(negedge clk_i); bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1;
    @(negedge clk_i); bus_wr_i = 0;
  endtask

  task automatic bus_read(logic a, output logic [7:0] d);
    @(negedge clk_i); bus_addr_i = a; bus_rd_i = 1; #1 d = bus_rdata_o;
    @(negedge clk_i); bus_rd_i = 0;
  endtask

  task automatic rx_push(logic [7:0] d, logic pe, logic fe);
    @(negedge clk_i); rx_data_i = d; rx_pe_i = pe; rx_fe_i = fe; rx_load_i = 1;
    @(negedge clk_i); rx_load_i = 0; rx_pe_i = 0; rx_fe_i = 0;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    bus_read(1, s);
    check("R1 status", s, 8'h01);
    check("R1 irq", {7'd0, rx_irq_o}, 8'h00);
  endtask

  task automatic t_rx_basic;
    logic [7:0] s, d;
    bus_write(1, 8'hC0);
    rx_push(8'hA5, 0, 0);
    bus_read(1, s);
    check("R3 full set", s & 8'h02, 8'h02);
    check("R5 irq on", {7'd0, rx_irq_o}, 8'h01);
    bus_write(0, 8'h3C);
    bus_read(0, d);
    check("R2/R4 rx data", d, 8'hA5);
    bus_read(1, s);
    check("R3 full cleared", s & 8'h02, 8'h00);
    check("R5 irq off", {7'd0, rx_irq_o}, 8'h00);
    @(negedge clk_i); tx_busy_i = 0;
    @(negedge clk_i); tx_busy_i = 1;
  endtask

  task automatic t_overrun;
    logic [7:0] s, d;
    rx_push(8'h11, 0, 0);
    rx_push(8'h22, 0, 0);
    bus_read(1, s);
    check("R6 ore set", s & 8'h10, 8'h10);
    bus_read(0, d);
    check("R6 old kept", d, 8'h11);
    bus_read(1, s);
    check("R6 ore cleared", s & 8'h12, 8'h00);
  endtask

  task automatic t_errors;
    logic [7:0] s, d;
    rx_push(8'h33, 1, 0);
    bus_read(1, s);
    check("R7 parity", s & 8'h0C, 8'h04);
    bus_read(0, d);
    rx_push(8'h44, 0, 1);
    bus_read(1, s);
    check("R7 framing", s & 8'h0C, 8'h08);
    bus_read(0, d);
  endtask

  task automatic t_short;
    logic [7:0] d;
    bus_write(1, 8'hE0);
    rx_push(8'hFF, 0, 0);
    bus_read(0, d);
    check("R8 rx bit7", d, 8'h7F);
    tx_busy_i = 0;
    bus_write(0, 8'hFF);
    #1;
    check("R8/R10 take", {7'd0, tx_take_o}, 8'h01);
    check("R8 tx bit7", tx_data_o, 8'h7F);
    @(negedge clk_i); tx_busy_i = 1;
    bus_write(1, 8'hC0);
  endtask

  task automatic t_tx;
    logic [7:0] s;
    bus_write(0, 8'h5A);
    bus_read(1, s);
    check("R9 empty cleared", s & 8'h01, 8'h00);
    check("R10 no take busy", {7'd0, tx_take_o}, 8'h00);
    @(negedge clk_i); tx_busy_i = 0; #1;
    check("R10 take", {7'd0, tx_take_o}, 8'h01);
    check("R10 tx data", tx_data_o, 8'h5A);
    @(negedge clk_i); tx_busy_i = 1;
    bus_read(1, s);
    check("R10 empty back", s & 8'h01, 8'h01);
  endtask

  task automatic t_tx_disabled;
    logic [7:0] s;
    bus_write(1, 8'h80);
    tx_busy_i = 0;
    bus_write(0, 8'h99);
    #1;
    check("R11 no take", {7'd0, tx_take_o}, 8'h00);
    bus_read(1, s);
    check("R11 empty kept", s & 8'h01, 8'h01);
    tx_busy_i = 1;
    bus_write(1, 8'h40);
    rx_push(8'h77, 0, 0);
    #1;
    check("R5 irq masked", {7'd0, rx_irq_o}, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        t_reset();
        t_rx_basic();
        t_overrun();
        t_errors();
        t_short();
        t_tx();
        t_tx_disabled();
      end
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule